// File: doc/BRIEF.md
# Row-Hit-First Request Selector

This block holds the pending requests of one DRAM channel in arrival order and, every cycle, decides which of them should be issued next. Each queued request carries a bank number, a row number and an opaque tag. A small per-bank table of open rows sits alongside the queue. In row-hit-first mode the selector picks the oldest request whose row is already open in its bank. When no such request exists, it falls back to the oldest request. A mode pin switches to strict arrival order, where the oldest request always wins.

Requests enter through a valid/ready stream. The selection leaves through a second valid/ready stream. A completed handshake on the output removes the chosen request, and the remaining requests close up in their original order. The `promote` control pin moves the current choice to the front of the queue without issuing it. The activate and precharge pins keep the open-row table in step with the commands the controller sends. Command timing and the DRAM commands themselves belong to the surrounding controller.

Back-pressure rules: `enq_ready` is low only while all slots are occupied, and it does not depend on `pick_ready`. While `pick_valid` is high and `pick_ready` is low, the offered request stays the same, unless one of these happens: the table changes, an enqueue is accepted, `promote` is pulsed, or the mode changes. `BANKS` must be a power of two, and `DEPTH` must be at least 2.

Top module: `rowhit_pick_top`

## Requirements
- R1: After reset the queue is empty (`pick_valid` = 0, `enq_ready` = 1) and every bank is marked closed.
- R2: With `policy` = 0 (arrival order), `pick_idx` is 0, the oldest slot.
- R3: With `policy` = 1, `pick_idx` is the lowest slot whose bank is open on the same row, and `pick_hit` is 1.
- R4: With `policy` = 1 and no row hit in the queue, `pick_idx` is 0 and `pick_hit` is 0.
- R5: An empty queue drives `pick_valid` low.
- R6: With exactly one request queued, that request (slot 0) is offered.
- R7: A handshake (`pick_valid` and `pick_ready`) removes the offered request. The other requests keep their relative order from the next cycle on.
- R8: `promote` moves the offered request to slot 0 and keeps the order of the others. It has no effect when a handshake happens in the same cycle or when the queue is empty.
- R9: `enq_ready` is 1 exactly when fewer than `DEPTH` requests are held. An accepted request is placed behind all others, including behind the gap left by a same-cycle removal. A request offered while full is dropped.
- R10: `act_valid` marks `act_bank` open on `act_row`, and `pre_valid` marks `pre_bank` closed. When both name the same bank in the same cycle, the activate wins. The change affects selection from the next cycle.
- R11: While the output is stalled and nothing else changes the inputs to the choice, the offered slot and request stay the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 1 | 0 = arrival order, 1 = row-hit first |
| enq_valid | input | 1 | New request offered |
| enq_ready | output | 1 | Queue can accept a request |
| enq_bank | input | $clog2(BANKS) | Bank of the new request |
| enq_row | input | ROW_W | Row of the new request |
| enq_tag | input | TAG_W | Opaque tag of the new request |
| pick_valid | output | 1 | A choice is offered |
| pick_ready | input | 1 | Consumer takes the offered request |
| pick_idx | output | $clog2(DEPTH) | Queue slot of the choice (0 = oldest) |
| pick_bank | output | $clog2(BANKS) | Bank of the choice |
| pick_row | output | ROW_W | Row of the choice |
| pick_tag | output | TAG_W | Tag of the choice |
| pick_hit | output | 1 | Choice targets its bank's open row |
| promote | input | 1 | Move the choice to slot 0 |
| act_valid | input | 1 | Activate issued |
| act_bank | input | $clog2(BANKS) | Bank being activated |
| act_row | input | ROW_W | Row being activated |
| pre_valid | input | 1 | Precharge issued |
| pre_bank | input | $clog2(BANKS) | Bank being precharged |

## Verification
The offered choice is computed combinationally from registered state and the `policy` pin. A change of `policy` therefore shows in the same cycle. An enqueue, removal, promotion, activate or precharge shows only after the next rising edge. The bench drives inputs on the falling edge and samples the outputs 2 ns later, still inside the same cycle. It advances its reference queue and open-row model only after the rising edge that commits the handshakes it drove. Each check therefore compares against the state that existed one edge after the stimulus.

// File: rtl/rhs_pkg.sv
package rhs_pkg;
  typedef enum logic {
    POL_FCFS   = 1'b0,
    POL_ROWHIT = 1'b1
  } pick_pol_e;
endpackage

// File: rtl/rhs_open_rows.sv
module rhs_open_rows #(
  parameter int BANKS = 8,
  parameter int ROW_W = 14
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              act_en,
  input  logic [$clog2(BANKS)-1:0]          act_bank,
  input  logic [ROW_W-1:0]                  act_row,
  input  logic                              pre_en,
  input  logic [$clog2(BANKS)-1:0]          pre_bank,
  output logic [BANKS-1:0]                  open_vld,
  output logic [BANKS-1:0][ROW_W-1:0]       open_row
);
  localparam int BANK_W = $clog2(BANKS);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit_act;
    logic hit_pre;
    assign hit_act = act_en && (act_bank == BANK_W'(b));
    assign hit_pre = pre_en && (pre_bank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_vld[b] <= 1'b0;
        open_row[b] <= '0;
      end else if (hit_act) begin
        open_vld[b] <= 1'b1;
        open_row[b] <= act_row;
      end else if (hit_pre) begin
        open_vld[b] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rhs_hit_match.sv
module rhs_hit_match #(
  parameter int DEPTH = 8,
  parameter int BANKS = 8,
  parameter int ROW_W = 14
) (
  input  logic [DEPTH-1:0]                      occ,
  input  logic [DEPTH-1:0][$clog2(BANKS)-1:0]   q_bank,
  input  logic [DEPTH-1:0][ROW_W-1:0]           q_row,
  input  logic [BANKS-1:0]                      open_vld,
  input  logic [BANKS-1:0][ROW_W-1:0]           open_row,
  output logic [DEPTH-1:0]                      hit
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_comb begin
      hit[i] = occ[i] && open_vld[q_bank[i]] && (open_row[q_bank[i]] == q_row[i]);
    end
  end
endmodule

// File: rtl/rhs_first_one.sv
module rhs_first_one #(
  parameter int N = 8
) (
  input  logic [N-1:0]         vec,
  output logic [$clog2(N)-1:0] idx,
  output logic                 any
);
  localparam int IDX_W = $clog2(N);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  assign any = |vec;
endmodule

// File: rtl/rhs_age_queue.sv
module rhs_age_queue #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int TAG_W  = 6
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                enq_en,
  input  logic [BANK_W-1:0]                   enq_bank,
  input  logic [ROW_W-1:0]                    enq_row,
  input  logic [TAG_W-1:0]                    enq_tag,
  input  logic                                rm_en,
  input  logic                                mv_en,
  input  logic [$clog2(DEPTH)-1:0]            sel_idx,
  output logic [DEPTH-1:0]                    occ,
  output logic [DEPTH-1:0][BANK_W-1:0]        q_bank,
  output logic [DEPTH-1:0][ROW_W-1:0]         q_row,
  output logic [DEPTH-1:0][TAG_W-1:0]         q_tag,
  output logic [$clog2(DEPTH+1)-1:0]          cnt
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [TAG_W-1:0]  tag;
  } slot_t;

  slot_t             mem   [DEPTH];
  slot_t             ext   [DEPTH+1];
  slot_t             nxt   [DEPTH];
  logic [CNT_W-1:0]  cnt_base;
  logic [CNT_W-1:0]  cnt_nxt;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) ext[i] = mem[i];
    ext[DEPTH] = '0;
    cnt_base = cnt - CNT_W'(rm_en);

    for (int i = 0; i < DEPTH; i++) begin
      int below;
      below = (i == 0) ? 0 : i - 1;
      if (rm_en) begin
        nxt[i] = (IDX_W'(i) < sel_idx) ? ext[i] : ext[i+1];
      end else if (mv_en) begin
        if (i == 0)                      nxt[i] = ext[sel_idx];
        else if (IDX_W'(i) <= sel_idx)   nxt[i] = ext[below];
        else                             nxt[i] = ext[i];
      end else begin
        nxt[i] = mem[i];
      end
      if (enq_en && (cnt_base == CNT_W'(i))) begin
        nxt[i] = '{bank: enq_bank, row: enq_row, tag: enq_tag};
      end
    end

    cnt_nxt = cnt_base + CNT_W'(enq_en);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      cnt <= cnt_nxt;
      for (int i = 0; i < DEPTH; i++) mem[i] <= nxt[i];
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_out
    assign occ[i]    = CNT_W'(i) < cnt;
    assign q_bank[i] = mem[i].bank;
    assign q_row[i]  = mem[i].row;
    assign q_tag[i]  = mem[i].tag;
  end
endmodule

// File: rtl/rowhit_pick_top.sv
module rowhit_pick_top #(
  parameter int DEPTH = 8,
  parameter int BANKS = 8,
  parameter int ROW_W = 14,
  parameter int TAG_W = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         policy,
  input  logic                         enq_valid,
  output logic                         enq_ready,
  input  logic [$clog2(BANKS)-1:0]     enq_bank,
  input  logic [ROW_W-1:0]             enq_row,
  input  logic [TAG_W-1:0]             enq_tag,
  output logic                         pick_valid,
  input  logic                         pick_ready,
  output logic [$clog2(DEPTH)-1:0]     pick_idx,
  output logic [$clog2(BANKS)-1:0]     pick_bank,
  output logic [ROW_W-1:0]             pick_row,
  output logic [TAG_W-1:0]             pick_tag,
  output logic                         pick_hit,
  input  logic                         promote,
  input  logic                         act_valid,
  input  logic [$clog2(BANKS)-1:0]     act_bank,
  input  logic [ROW_W-1:0]             act_row,
  input  logic                         pre_valid,
  input  logic [$clog2(BANKS)-1:0]     pre_bank
);
  import rhs_pkg::*;

  localparam int BANK_W = $clog2(BANKS);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]                  occ;
  logic [DEPTH-1:0][BANK_W-1:0]      q_bank;
  logic [DEPTH-1:0][ROW_W-1:0]       q_row;
  logic [DEPTH-1:0][TAG_W-1:0]       q_tag;
  logic [CNT_W-1:0]                  q_cnt;
  logic [BANKS-1:0]                  open_vld;
  logic [BANKS-1:0][ROW_W-1:0]       open_row;
  logic [DEPTH-1:0]                  hit_vec;
  logic [IDX_W-1:0]                  first_hit;
  logic                              any_hit;
  logic [IDX_W-1:0]                  sel_idx;
  logic                              enq_fire;
  logic                              issue;
  logic                              mv_en;
  pick_pol_e                         pol;

  assign pol = pick_pol_e'(policy);

  rhs_open_rows #(.BANKS(BANKS), .ROW_W(ROW_W)) rows_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_en   (act_valid),
    .act_bank (act_bank),
    .act_row  (act_row),
    .pre_en   (pre_valid),
    .pre_bank (pre_bank),
    .open_vld (open_vld),
    .open_row (open_row)
  );

  rhs_hit_match #(.DEPTH(DEPTH), .BANKS(BANKS), .ROW_W(ROW_W)) match_i (
    .occ      (occ),
    .q_bank   (q_bank),
    .q_row    (q_row),
    .open_vld (open_vld),
    .open_row (open_row),
    .hit      (hit_vec)
  );

  rhs_first_one #(.N(DEPTH)) prio_i (
    .vec (hit_vec),
    .idx (first_hit),
    .any (any_hit)
  );

  always_comb begin
    sel_idx = '0;
    if (pol == POL_ROWHIT && any_hit) sel_idx = first_hit;
  end

  assign pick_valid = occ[0];
  assign enq_ready  = !occ[DEPTH-1];
  assign enq_fire   = enq_valid && enq_ready;
  assign issue      = pick_valid && pick_ready;
  assign mv_en      = promote && pick_valid && !issue;

  rhs_age_queue #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .TAG_W(TAG_W)) queue_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enq_en   (enq_fire),
    .enq_bank (enq_bank),
    .enq_row  (enq_row),
    .enq_tag  (enq_tag),
    .rm_en    (issue),
    .mv_en    (mv_en),
    .sel_idx  (sel_idx),
    .occ      (occ),
    .q_bank   (q_bank),
    .q_row    (q_row),
    .q_tag    (q_tag),
    .cnt      (q_cnt)
  );

  assign pick_idx  = sel_idx;
  assign pick_bank = q_bank[sel_idx];
  assign pick_row  = q_row[sel_idx];
  assign pick_tag  = q_tag[sel_idx];
  assign pick_hit  = hit_vec[sel_idx];
endmodule

// File: rtl/rowhit_pick_chk.sv
module rowhit_pick_chk #(
  parameter int DEPTH = 8,
  parameter int BANKS = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        policy,
  input logic                        enq_valid,
  input logic                        enq_ready,
  input logic                        pick_valid,
  input logic                        pick_ready,
  input logic [$clog2(DEPTH)-1:0]    pick_idx,
  input logic                        pick_hit,
  input logic                        promote,
  input logic                        act_valid,
  input logic [$clog2(BANKS)-1:0]    act_bank,
  input logic                        pre_valid,
  input logic [$clog2(BANKS)-1:0]    pre_bank,
  input logic [$clog2(DEPTH+1)-1:0]  q_cnt,
  input logic [BANKS-1:0]            open_vld
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  // R2
  fcfs_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && !policy) |-> (pick_idx == '0));

  // R4
  miss_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && !pick_hit) |-> (pick_idx == '0));

  // R6
  single_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt == CNT_W'(1)) |-> (pick_valid && pick_idx == '0));

  // R9
  occupancy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q_cnt == $past(q_cnt) + CNT_W'($past(enq_valid && enq_ready))
                                    - CNT_W'($past(pick_valid && pick_ready))));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CNT_W'(DEPTH));

  // R10
  act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |=> open_vld[$past(act_bank)]);

  // R10
  pre_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_valid && !(act_valid && act_bank == pre_bank)) |=> !open_vld[$past(pre_bank)]);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && !pick_ready && !promote && !act_valid && !pre_valid
     && !(enq_valid && enq_ready))
    |=> ((policy != $past(policy)) || (pick_valid && $stable(pick_idx))));
endmodule

bind rowhit_pick_top rowhit_pick_chk #(.DEPTH(DEPTH), .BANKS(BANKS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .policy     (policy),
  .enq_valid  (enq_valid),
  .enq_ready  (enq_ready),
  .pick_valid (pick_valid),
  .pick_ready (pick_ready),
  .pick_idx   (pick_idx),
  .pick_hit   (pick_hit),
  .promote    (promote),
  .act_valid  (act_valid),
  .act_bank   (act_bank),
  .pre_valid  (pre_valid),
  .pre_bank   (pre_bank),
  .q_cnt      (q_cnt),
  .open_vld   (open_vld)
);

// File: tb/rowhit_pick_tb.sv
`timescale 1ns/1ps
module rowhit_pick_top_tb_top;
  localparam int DEPTH = 8;
  localparam int BANKS = 4;
  localparam int ROW_W = 3;
  localparam int TAG_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic policy = 1'b1;
  logic enq_valid = 1'b0;
  logic enq_ready;
  logic [1:0] enq_bank = '0;
  logic [ROW_W-1:0] enq_row = '0;
  logic [TAG_W-1:0] enq_tag = '0;
  logic pick_valid;
  logic pick_ready = 1'b0;
  logic [2:0] pick_idx;
  logic [1:0] pick_bank;
  logic [ROW_W-1:0] pick_row;
  logic [TAG_W-1:0] pick_tag;
  logic pick_hit;
  logic promote = 1'b0;
  logic act_valid = 1'b0;
  logic [1:0] act_bank = '0;
  logic [ROW_W-1:0] act_row = '0;
  logic pre_valid = 1'b0;
  logic [1:0] pre_bank = '0;

  always #10 clk = ~clk;

  rowhit_pick_top #(.DEPTH(DEPTH), .BANKS(BANKS), .ROW_W(ROW_W), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .policy(policy),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_bank(enq_bank),
    .enq_row(enq_row), .enq_tag(enq_tag),
    .pick_valid(pick_valid), .pick_ready(pick_ready), .pick_idx(pick_idx),
    .pick_bank(pick_bank), .pick_row(pick_row), .pick_tag(pick_tag),
    .pick_hit(pick_hit), .promote(promote),
    .act_valid(act_valid), .act_bank(act_bank), .act_row(act_row),
    .pre_valid(pre_valid), .pre_bank(pre_bank)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model
  int mb [DEPTH];
  int mr [DEPTH];
  int mt [DEPTH];
  int qn = 0;
  bit ov [BANKS];
  int orw [BANKS];
  int next_tag = 0;

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic bit is_hit(int i);
    return ov[mb[i]] && (orw[mb[i]] == mr[i]);
  endfunction

  function automatic int exp_idx(bit pol);
    if (qn == 0 || !pol) return 0;
    for (int i = 0; i < qn; i++) if (is_hit(i)) return i;
    return 0;
  endfunction

  function automatic bit any_hit();
    for (int i = 0; i < qn; i++) if (is_hit(i)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(string rq, bit pol, bit ev, int eb, int er, bit pr, bit prom,
                      bit av, int ab, int ar, bit pv, int pb);
    string lab;
    int e;
    bit iss, prm, enq;
    @(negedge clk);
    policy = pol; enq_valid = ev; enq_bank = 2'(eb); enq_row = ROW_W'(er);
    enq_tag = TAG_W'(next_tag); pick_ready = pr; promote = prom;
    act_valid = av; act_bank = 2'(ab); act_row = ROW_W'(ar);
    pre_valid = pv; pre_bank = 2'(pb);
    #2;
    e = exp_idx(pol);
    if (qn == 0)           lab = "R5";
    else if (qn == 1)      lab = "R6";
    else if (!pol)         lab = "R2";
    else if (any_hit())    lab = "R3";
    else                   lab = "R4";
    if (rq != "") lab = rq;
    chk(pick_valid == (qn > 0), lab, "pick_valid", int'(pick_valid), int'(qn > 0));
    chk(enq_ready == (qn < DEPTH), (rq != "") ? rq : "R9", "enq_ready", int'(enq_ready), int'(qn < DEPTH));
    if (qn > 0) begin
      chk(int'(pick_idx) == e, lab, "pick_idx", int'(pick_idx), e);
      chk(int'(pick_tag) == (mt[e] & 8'hff), lab, "pick_tag", int'(pick_tag), mt[e] & 8'hff);
      chk(pick_hit == is_hit(e), lab, "pick_hit", int'(pick_hit), int'(is_hit(e)));
    end
    @(posedge clk);
    iss = pr && (qn > 0);
    prm = prom && (qn > 0) && !iss;
    enq = ev && (qn < DEPTH);
    if (iss) begin
      for (int i = e; i < qn - 1; i++) begin
        mb[i] = mb[i+1]; mr[i] = mr[i+1]; mt[i] = mt[i+1];
      end
      qn--;
    end else if (prm) begin
      int sb, sr, st;
      sb = mb[e]; sr = mr[e]; st = mt[e];
      for (int i = e; i > 0; i--) begin
        mb[i] = mb[i-1]; mr[i] = mr[i-1]; mt[i] = mt[i-1];
      end
      mb[0] = sb; mr[0] = sr; mt[0] = st;
    end
    if (enq) begin
      mb[qn] = eb; mr[qn] = er; mt[qn] = next_tag & 8'hff;
      qn++;
      next_tag++;
    end
    if (pv) ov[pb] = 1'b0;
    if (av) begin ov[ab] = 1'b1; orw[ab] = ar; end
  endtask

  task automatic idle(string rq, bit pol);
    step(rq, pol, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    #4000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = 32'h5eed1234;
    void'($urandom(seed));
    for (int b = 0; b < BANKS; b++) begin ov[b] = 1'b0; orw[b] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1: reset state
    chk(pick_valid == 1'b0, "R1", "pick_valid", int'(pick_valid), 0);
    chk(enq_ready == 1'b1, "R1", "enq_ready", int'(enq_ready), 1);

    // tags 0,1,2 : b0r1, b1r2, b0r3
    step("R5", 1, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    step("R6", 1, 1, 1, 2, 0, 0, 0, 0, 0, 0, 0);
    step("R1", 1, 1, 0, 3, 0, 0, 0, 0, 0, 0, 0);  // banks closed after reset: no hit
    step("R4", 1, 0, 0, 0, 0, 0, 1, 1, 2, 0, 0);  // activate bank1 row2
    idle("R3", 1);                                 // tag1 at slot1 now hits
    idle("R2", 0);
    step("R8", 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);   // promote tag1
    idle("R8", 0);                                  // order 1,0,2
    step("R7", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);   // issue tag1
    idle("R7", 0);                                  // order 0,2
    idle("R11", 1);
    idle("R11", 1);
    for (int k = 0; k < 6; k++) step("R9", 1, 1, k % 4, k, 0, 0, 0, 0, 0, 0, 0);
    step("R9", 1, 1, 3, 7, 0, 0, 0, 0, 0, 0, 0);   // full: dropped
    step("R8", 1, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);   // issue wins over promote
    step("R9", 1, 1, 2, 5, 1, 0, 0, 0, 0, 0, 0);   // enqueue with same-cycle issue
    for (int k = 0; k < 8; k++) step("R7", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    step("R8", 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);   // promote on empty
    step("R10", 1, 1, 2, 5, 0, 0, 1, 2, 5, 1, 2);  // act and pre same bank
    step("R10", 1, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    idle("R10", 1);
    step("R10", 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2);  // close bank2
    idle("R10", 1);

    for (int k = 0; k < 4000; k++) begin
      step("", ($urandom % 4) != 0, ($urandom % 10) < 6, $urandom % 4, $urandom % 8,
           ($urandom % 10) < 4, ($urandom % 5) == 0,
           ($urandom % 7) == 0, $urandom % 4, $urandom % 8,
           ($urandom % 10) == 0, $urandom % 4);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule